// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits between a processor-side configuration window and a PCI configuration-bus master. A processor access inside the window carries only its low sixteen address bits into the translation. The upper sixteen bits come from a software-owned map-configuration value, supplied to the block as an input. The two halves form a 32-bit composite address. Its upper field, composite bits [31:11], is a one-hot slot-select field. The block encodes that field into a 5-bit device number by taking the position of its lowest set bit. It also passes through the function and register fields and adds the bus number from a static input. The result is an enable-flagged type-0 configuration address for the downstream master.

The block also works out the byte enables and shifts the write data onto the correct lanes for 1-, 2- and 4-byte accesses. It flags accesses that are not word aligned. With every valid request it pulses a strobe that clears the bridge's received-abort status bits. An access is invalid when a non-type-0 request is configured, when the slot-select field is empty, or when the size code is illegal. Such an access issues no request. Instead it raises a one-cycle error pulse, and for reads it also supplies all-ones fill data sized to the access. All outputs are registered, appear on the cycle after the request strobe, and last one cycle.

Top module: `cfgwin_xlat`

## Requirements
- R1: A valid request drives `out_addr` = {1'b1, 7'b0, bus[7:0], dev[4:0], fn[2:0], reg[7:0]}, where the composite address is {map_cfg[15:0], req_addr[15:0]} and req_addr bits above 15 have no effect.
- R2: When map_cfg bit 16 is 1 (a non-type-0 request), the access is invalid: `err_pulse` is 1 and `out_valid` is 0.
- R3: The device number in `out_addr[15:11]` equals the index of the lowest set bit of composite bits [31:11], even when higher bits of that field are also set.
- R4: A composite slot-select field [31:11] that is all zero makes the access invalid, with `err_pulse` 1 and no request.
- R5: `out_addr[10:8]` carries composite bits [10:8] (function) and `out_addr[7:0]` carries composite bits [7:0] (register).
- R6: `out_addr[23:16]` equals the `bus_num` input at the time of the request.
- R7: On an invalid read, `err_rdata` is 32'h000000FF for size code 0, 32'h0000FFFF for size code 1, and 32'hFFFFFFFF for size codes 2 and 3. On an invalid write, `err_rdata` is 0 and the write is dropped (no `out_valid`).
- R8: Size code 0/1/2 means 1/2/4 bytes. `out_be` is the mask of that many low lanes shifted left by req_addr[1:0] and cut to 4 bits. `out_wdata` is req_wdata shifted left by 8*req_addr[1:0] and cut to 32 bits.
- R9: `out_subword` is 1 on a valid request exactly when req_addr[1:0] is nonzero.
- R10: `abort_clr` pulses with every valid translated request and never with an invalid one.
- R11: All outputs are registered. They reflect a request on the cycle after `req_valid` is sampled and are all zero on any cycle that follows no request, including after reset.
- R12: Size code 3 is illegal and makes the access invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 19 | Byte offset inside the configuration window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| req_wdata | input | 32 | Write data, right-aligned |
| map_cfg | input | 32 | Map-configuration value: [15:0] upper address half, [16] non-type-0 |
| bus_num | input | 8 | Static bus number |
| out_valid | output | 1 | Downstream configuration request |
| out_write | output | 1 | Request is a write |
| out_addr | output | 32 | Enable-flagged configuration address |
| out_be | output | 4 | Byte-lane enables |
| out_wdata | output | 32 | Lane-aligned write data |
| out_subword | output | 1 | Access is not word aligned |
| err_pulse | output | 1 | Invalid access |
| err_rdata | output | 32 | All-ones fill for an invalid read |
| abort_clr | output | 1 | Clear received-master/target-abort status |

## Verification
The assertions assume that `req_valid` is low while reset is held, that all request inputs are at known values whenever `req_valid` is sampled, and that `bus_num` and `map_cfg` do not change between a strobe and its capture. The stimulus drives every input at the falling edge, keeps the strobe to a single cycle with an idle cycle after it, and holds all inputs at zero through reset. The sweep moves the lowest slot-select bit across all 21 positions and also uses an empty field. For each of these it runs every size code, read and write, and both request types. Some cases also set a higher slot-select bit, some put nonzero bits in the window address above bit 15, and some change the bus number, so the tests that something has no effect are all seen at the outputs.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic        valid;
      logic        write;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        subword;
      logic        err;
      logic [31:0] fill;
      logic        clr;
   } xlat_out_t;

   // All-ones read fill sized to the access; illegal size fills the word.
   function automatic logic [31:0] fill_for(acc_size_e sz);
      case (sz)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_HALF: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cfgx_idsel_enc.sv
module cfgx_idsel_enc #(
   parameter int SEL_W = 21,
   parameter int IDX_W = 5
) (
   input  logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] idx,
   output logic             none
);

   generate
      if (SEL_W > (1 << IDX_W)) begin : g_bad_width
         $error("cfgx_idsel_enc: SEL_W does not fit in IDX_W bits");
      end
   endgenerate

   // Lowest set bit wins: scan from the top so the last hit is the lowest.
   always_comb begin
      idx = '0;
      for (int i = SEL_W - 1; i >= 0; i--) begin
         if (sel[i]) idx = IDX_W'(i);
      end
   end

   assign none = ~|sel;

endmodule

// File: rtl/cfgx_lane_gen.sv
module cfgx_lane_gen #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  cfgx_pkg::acc_size_e size,
   input  logic [OFF_W-1:0]    off,
   input  logic [DATA_W-1:0]   wdata,
   output logic [LANES-1:0]    be,
   output logic [DATA_W-1:0]   wdata_al
);
   import cfgx_pkg::*;

   generate
      if (DATA_W % 8 != 0 || LANES < 4) begin : g_bad_width
         $error("cfgx_lane_gen: DATA_W must be a multiple of 8, at least 32");
      end
   endgenerate

   logic [LANES-1:0] base_mask;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         if (i == 0) begin : g_first
            assign base_mask[i] = 1'b1;
         end else if (i == 1) begin : g_second
            assign base_mask[i] = (size != SZ_BYTE);
         end else begin : g_upper
            assign base_mask[i] = (size == SZ_WORD) || (size == SZ_BAD);
         end
      end
   endgenerate

   assign be       = base_mask << off;
   assign wdata_al = wdata << {off, 3'b000};

endmodule

// File: rtl/cfgx_out_stage.sv
module cfgx_out_stage (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  cfgx_pkg::xlat_out_t nxt,
   output cfgx_pkg::xlat_out_t cur
);
   import cfgx_pkg::*;

   // Every output lasts exactly one cycle: an idle cycle clears the stage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= '0;
      else if (load) cur <= nxt;
      else           cur <= '0;
   end

endmodule

// File: rtl/cfgwin_xlat.sv
module cfgwin_xlat #(
   parameter int WIN_AW  = 19,
   parameter int LOW_W   = 16,
   parameter int BUS_W   = 8,
   parameter int DATA_W  = 32,
   parameter int SEL_LSB = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [WIN_AW-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [31:0]       map_cfg,
   input  logic [BUS_W-1:0]  bus_num,
   output logic              out_valid,
   output logic              out_write,
   output logic [31:0]       out_addr,
   output logic [3:0]        out_be,
   output logic [DATA_W-1:0] out_wdata,
   output logic              out_subword,
   output logic              err_pulse,
   output logic [31:0]       err_rdata,
   output logic              abort_clr
);
   import cfgx_pkg::*;

   localparam int COMP_W = 2 * LOW_W;
   localparam int SEL_W  = COMP_W - SEL_LSB;
   localparam int DEV_W  = 5;
   localparam int LANES  = DATA_W / 8;
   localparam int OFF_W  = $clog2(LANES);
   localparam int TYPE_BIT = LOW_W;

   generate
      if (WIN_AW < LOW_W) begin : g_bad_win
         $error("cfgwin_xlat: window narrower than the low address half");
      end
      if (COMP_W != 32 || BUS_W != 8 || DATA_W != 32) begin : g_bad_fmt
         $error("cfgwin_xlat: configuration address format needs 32/8/32");
      end
   endgenerate

   logic [COMP_W-1:0] comp;
   logic [SEL_W-1:0]  idsel;
   logic [DEV_W-1:0]  dev;
   logic              sel_none;
   logic              bad;
   acc_size_e         size;
   logic [LANES-1:0]  be;
   logic [DATA_W-1:0] wdata_al;
   xlat_out_t         nxt;
   xlat_out_t         cur;

   assign size  = acc_size_e'(req_size);
   assign comp  = {map_cfg[LOW_W-1:0], req_addr[LOW_W-1:0]};
   assign idsel = comp[COMP_W-1:SEL_LSB];

   cfgx_idsel_enc #(.SEL_W(SEL_W), .IDX_W(DEV_W)) enc_i (
      .sel  (idsel),
      .idx  (dev),
      .none (sel_none)
   );

   cfgx_lane_gen #(.DATA_W(DATA_W)) lane_i (
      .size     (size),
      .off      (req_addr[OFF_W-1:0]),
      .wdata    (req_wdata),
      .be       (be),
      .wdata_al (wdata_al)
   );

   assign bad = map_cfg[TYPE_BIT] | sel_none | (size == SZ_BAD);

   always_comb begin
      nxt = '0;
      if (bad) begin
         nxt.err  = 1'b1;
         nxt.fill = req_write ? 32'h0 : fill_for(size);
      end else begin
         nxt.valid   = 1'b1;
         nxt.write   = req_write;
         nxt.addr    = {1'b1, 7'b0, bus_num, dev, comp[SEL_LSB-1:0]};
         nxt.be      = be;
         nxt.wdata   = wdata_al;
         nxt.subword = |req_addr[OFF_W-1:0];
         nxt.clr     = 1'b1;
      end
   end

   cfgx_out_stage stage_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (req_valid),
      .nxt   (nxt),
      .cur   (cur)
   );

   assign out_valid   = cur.valid;
   assign out_write   = cur.write;
   assign out_addr    = cur.addr;
   assign out_be      = cur.be;
   assign out_wdata   = cur.wdata;
   assign out_subword = cur.subword;
   assign err_pulse   = cur.err;
   assign err_rdata   = cur.fill;
   assign abort_clr   = cur.clr;

endmodule

// File: rtl/cfgwin_xlat_chk.sv
module cfgwin_xlat_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [18:0] req_addr,
   input logic [1:0]  req_size,
   input logic [31:0] map_cfg,
   input logic        out_valid,
   input logic        out_write,
   input logic [31:0] out_addr,
   input logic [3:0]  out_be,
   input logic        out_subword,
   input logic        err_pulse,
   input logic [31:0] err_rdata,
   input logic        abort_clr
);

   AST_ENABLE_FMT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr[31] && out_addr[30:24] == 7'd0)); // R1

   AST_NONTYPE0_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && map_cfg[16]) |-> (err_pulse && !out_valid)); // R2

   AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr[15:11] <= 5'd20)); // R3

   AST_IDSEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && map_cfg[15:0] == 16'd0 && req_addr[15:11] == 5'd0)
      |-> err_pulse); // R4

   AST_FILL_ONLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rdata != 32'd0) |-> (err_pulse && !$past(req_write))); // R7

   AST_BE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(req_size) == 2'd0) |-> ($countones(out_be) == 1)); // R8

   AST_SUBWORD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      out_subword |-> (out_valid && $past(req_addr[1:0]) != 2'd0)); // R9

   AST_CLR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      abort_clr |-> (out_valid && !err_pulse)); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> !(out_valid || err_pulse || abort_clr || out_write)); // R11

   AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_size == 2'd3) |-> (err_pulse && !out_valid)); // R12

endmodule

bind cfgwin_xlat cfgwin_xlat_chk chk_i (.*);

// File: tb/cfgwin_xlat_tb_top.sv
module cfgwin_xlat_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] map_cfg = '0;
   logic [7:0]  bus_num = '0;
   logic        out_valid, out_write, out_subword, err_pulse, abort_clr;
   logic [31:0] out_addr, out_wdata, err_rdata;
   logic [3:0]  out_be;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cfgwin_xlat dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .map_cfg(map_cfg), .bus_num(bus_num), .out_valid(out_valid),
      .out_write(out_write), .out_addr(out_addr), .out_be(out_be),
      .out_wdata(out_wdata), .out_subword(out_subword), .err_pulse(err_pulse),
      .err_rdata(err_rdata), .abort_clr(abort_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // One access: strobe, check registered result, then check idle cycle.
   task automatic run_one(input logic [31:0] comp, input logic [2:0] hi,
                          input logic type1, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd,
                          input logic [7:0] bus, input bit chk_idle);
      logic [20:0] sel;
      int          dev;
      logic        bad;
      logic [3:0]  mask;
      logic [31:0] fill;
      sel = comp[31:11];
      dev = 0;
      for (int i = 20; i >= 0; i--) if (sel[i]) dev = i;
      bad  = type1 || (sel == 21'd0) || (sz == 2'd3);
      mask = (sz == 2'd0) ? 4'h1 : (sz == 2'd1) ? 4'h3 : 4'hF;
      fill = wr ? 32'h0 : (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;

      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = {hi, comp[15:0]};
      req_size  = sz;
      req_wdata = wd;
      map_cfg   = {15'h0, type1, comp[31:16]};
      bus_num   = bus;
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         if (type1)           chk("R2 err on non-type-0", {31'b0, err_pulse}, 32'd1);
         else if (sel == '0)  chk("R4 err on empty idsel", {31'b0, err_pulse}, 32'd1);
         else                 chk("R12 err on size 3", {31'b0, err_pulse}, 32'd1);
         chk("R2 no request on error", {31'b0, out_valid}, 32'd0);
         chk("R7 fill data", err_rdata, fill);
         chk("R10 no abort clear on error", {31'b0, abort_clr}, 32'd0);
      end else begin
         chk("R1 valid and no error", {30'b0, out_valid, err_pulse}, 32'd2);
         chk("R1 addr enable and pad", {24'b0, out_addr[31:24]}, 32'h80);
         chk("R6 bus field", {24'b0, out_addr[23:16]}, {24'b0, bus});
         chk("R3 device from lowest idsel bit", {27'b0, out_addr[15:11]}, dev);
         chk("R5 function and register", {21'b0, out_addr[10:0]}, {21'b0, comp[10:0]});
         chk("R8 byte enables", {28'b0, out_be}, {28'b0, mask << comp[1:0]});
         chk("R8 lane data", out_wdata, wd << (8 * comp[1:0]));
         chk("R9 subword flag", {31'b0, out_subword}, {31'b0, comp[1:0] != 2'd0});
         chk("R10 abort clear", {31'b0, abort_clr}, 32'd1);
         chk("R1 write flag", {31'b0, out_write}, {31'b0, wr});
      end
      if (chk_idle) begin
         @(negedge clk);
         chk("R11 idle cycle quiet",
             {26'b0, out_valid, err_pulse, abort_clr, out_write, out_subword, |err_rdata},
             32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset outputs", {26'b0, out_valid, err_pulse, abort_clr, out_write,
                                out_subword, |out_addr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 first cycle after reset", {29'b0, out_valid, err_pulse, abort_clr}, 32'd0);

      for (int p = -1; p <= 20; p++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int t = 0; t < 2; t++) begin
               for (int w = 0; w < 2; w++) begin
                  logic [20:0] sel;
                  logic [10:0] low;
                  logic [31:0] comp;
                  int          k;
                  k   = (p + 1) * 16 + sz * 4 + t * 2 + w;
                  sel = (p < 0) ? 21'd0 : (21'd1 << p);
                  if (p >= 0 && p < 19 && (k % 3 == 0)) sel = sel | (21'd1 << (p + 2));
                  low  = 11'((k * 173 + 5) ^ (k << 3));
                  comp = {sel, low};
                  run_one(comp, 3'(k), t[0], 2'(sz), w[0], 32'hA5C3_1E70 ^ (k * 32'h0101_0101),
                          8'(k * 7), (k % 4 == 0));
               end
            end
         end
      end
      finished = 1'b1;
      summary();
   end

   initial begin
      for (int c = 0; c < 50000; c++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule